// File: doc/BRIEF.md
# SIMD Lane Predication Controller

This block steers a group of threads that run one shader program through a single shared instruction stream across parallel lanes. The group advances under one program counter, and the software sees no lane count. The controller keeps a per-lane write-enable mask and a stack of reconvergence entries. When lanes disagree on a branch, the controller plays each path that any lane takes one after the other. Lanes that are off the current path have their register writeback gated, so useful throughput can drop as low as one lane in S.

Commands arrive on a valid/ready stream. `cmd_ready` is held high and the block never pushes back: each cycle with `cmd_valid` high consumes one command, and a cycle with `cmd_valid` low changes nothing. The instruction sequencer sends a branch command with a per-lane condition. When the branch is uniform across the active lanes, the block pushes nothing and only reports whether the path should be skipped. The sequencer then handles that branch as a scalar jump and sends no else or join for it. When the branch is divergent, the sequencer later sends else at the end of the taken path and join at the reconvergence point. Loops are bracketed by a loop-open command and a join. Lanes that leave a loop early are removed with an exit command.

Top module: `simd_pred_ctrl`

## Requirements
- R1: After reset, every bit of `lane_we` is 1, `depth` is 0, and `ovf_err`, `unf_err`, `path_skip` and `diverged` are 0.
- R2: Opcode 0 (branch) with some but not all active lanes in `cmd_cond` is divergent. It sets `lane_we` to `lane_we & cmd_cond`, pushes an entry and raises `depth` by 1. It shows `cmd_rpc` on `top_rpc` and pulses `diverged` for one cycle. Bit i of every lane vector is lane i.
- R3: A branch with no active lane in `cmd_cond` pulses `path_skip` and leaves the mask and depth unchanged. The same holds when the mask is empty. A branch taken by all active lanes changes nothing and pulses nothing.
- R4: Opcode 1 (else) sets `lane_we` to the active lanes that were saved at the branch with a false condition, minus any lanes that have exited since. It pulses `path_skip` when that set is empty. Depth is unchanged.
- R5: Opcode 2 (join) pops the top entry and restores the mask that was active when that entry was pushed.
- R6: Opcode 3 (loop open) pushes an entry that holds the current mask and `cmd_rpc`. The mask is unchanged.
- R7: Opcode 4 (exit) clears the lanes set in `cmd_cond` from `lane_we`. It also clears them from every stacked entry above the innermost loop entry, or from all entries if no loop is open. It pulses `path_skip` when no lane remains. The lanes come back when the loop entry is joined.
- R8: A push while `depth` equals DEPTH sets the sticky `ovf_err` and leaves the mask and depth unchanged.
- R9: Else or join while `depth` is 0 sets the sticky `unf_err` and leaves the mask unchanged.
- R10: `cmd_ready` is always 1, and cycles with `cmd_valid` low leave all state unchanged.
- R11: Opcodes 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1 |
| cmd_op | input | 3 | Opcode |
| cmd_cond | input | LANES | Per-lane condition or exit lanes |
| cmd_rpc | input | PCW | Reconvergence PC for a push |
| lane_we | output | LANES | Register-file write enables |
| path_skip | output | 1 | One-cycle pulse: the path has no lanes, jump ahead |
| diverged | output | 1 | One-cycle pulse: a branch split the group |
| top_rpc | output | PCW | Reconvergence PC of the top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Stack occupancy |
| ovf_err | output | 1 | Sticky overflow |
| unf_err | output | 1 | Sticky underflow |

## Verification
The bench builds the block with 4 lanes and a stack depth of 2. At that size every pair of nested branch conditions (256 combinations) can be swept from a full mask. The sweep covers each uniform-taken, uniform-skip and divergent case at both nesting levels, along with the else and join unwinding that follows. The shallow stack lets overflow and underflow be reached in a few commands. Four lanes are enough to exit lanes from inside a nested branch within a loop and watch them return when the loop closes.

// File: rtl/simd_pred_pkg.sv
package simd_pred_pkg;
  typedef enum logic [2:0] {
    OP_BRANCH = 3'd0,
    OP_ELSE   = 3'd1,
    OP_JOIN   = 3'd2,
    OP_LOOP   = 3'd3,
    OP_EXIT   = 3'd4
  } lane_op_e;
endpackage

// File: rtl/simd_branch_eval.sv
module simd_branch_eval #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] taken,
  output logic [LANES-1:0] not_taken,
  output logic             none_taken,
  output logic             all_taken
);
  always_comb begin
    taken      = cur_mask & cond;
    not_taken  = cur_mask & ~cond;
    none_taken = (taken == '0);
    all_taken  = (not_taken == '0);
  end
endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PCW-1:0]   push_rpc,
  input  logic [LANES-1:0] push_else,
  input  logic [LANES-1:0] push_outer,
  input  logic             push_loop,
  input  logic             pop,
  input  logic             clr_en,
  input  logic [LANES-1:0] clr_lanes,
  output logic [PCW-1:0]   top_rpc,
  output logic [LANES-1:0] top_else,
  output logic [LANES-1:0] top_outer,
  output logic [SPW-1:0]   sp,
  output logic             full,
  output logic             empty
);
  logic [PCW-1:0]   rpc_q   [DEPTH];
  logic [LANES-1:0] else_q  [DEPTH];
  logic [LANES-1:0] outer_q [DEPTH];
  logic             loop_q  [DEPTH];
  logic [SPW-1:0]   sp_q;
  logic [SPW-1:0]   floor_sp;
  logic [IDXW-1:0]  top_idx;
  logic [IDXW-1:0]  wr_idx;

  assign sp      = sp_q;
  assign full    = (sp_q == SPW'(DEPTH));
  assign empty   = (sp_q == '0);
  assign top_idx = IDXW'(sp_q - SPW'(1));
  assign wr_idx  = IDXW'(sp_q);

  // one above the innermost open loop entry; 0 when no loop is open
  always_comb begin
    floor_sp = '0;
    for (int i = 0; i < DEPTH; i++)
      if (SPW'(i) < sp_q && loop_q[i]) floor_sp = SPW'(i + 1);
  end

  always_comb begin
    if (empty) begin
      top_rpc   = '0;
      top_else  = '0;
      top_outer = '0;
    end else begin
      top_rpc   = rpc_q[top_idx];
      top_else  = else_q[top_idx];
      top_outer = outer_q[top_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        rpc_q[i]   <= '0;
        else_q[i]  <= '0;
        outer_q[i] <= '0;
        loop_q[i]  <= 1'b0;
      end
    end else begin
      if (clr_en) begin
        for (int i = 0; i < DEPTH; i++)
          if (SPW'(i) >= floor_sp && SPW'(i) < sp_q) begin
            else_q[i]  <= else_q[i] & ~clr_lanes;
            outer_q[i] <= outer_q[i] & ~clr_lanes;
          end
      end
      if (push && !full) begin
        rpc_q[wr_idx]   <= push_rpc;
        else_q[wr_idx]  <= push_else;
        outer_q[wr_idx] <= push_outer;
        loop_q[wr_idx]  <= push_loop;
        sp_q            <= sp_q + SPW'(1);
      end else if (pop && !empty) begin
        sp_q <= sp_q - SPW'(1);
      end
    end
  end

  // R8: occupancy never passes the configured depth
  a_r8_sp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH));
  // R5: a pop from a non-empty stack lowers occupancy by one
  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> sp_q == $past(sp_q) - SPW'(1));
endmodule

// File: rtl/simd_pred_ctrl.sv
module simd_pred_ctrl
  import simd_pred_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [LANES-1:0] cmd_cond,
  input  logic [PCW-1:0]   cmd_rpc,
  output logic [LANES-1:0] lane_we,
  output logic             path_skip,
  output logic             diverged,
  output logic [PCW-1:0]   top_rpc,
  output logic [SPW-1:0]   depth,
  output logic             ovf_err,
  output logic             unf_err
);
  logic [LANES-1:0] mask_q, mask_d;
  logic             skip_q, skip_d, div_q, div_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic [LANES-1:0] taken, not_taken;
  logic             none_taken, all_taken;
  logic             st_push, st_pop, st_clr, st_loop, st_full, st_empty;
  logic [LANES-1:0] st_push_else, st_top_else, st_top_outer;
  logic [LANES-1:0] exit_mask;

  assign cmd_ready = 1'b1;
  assign exit_mask = mask_q & ~cmd_cond;

  simd_branch_eval #(.LANES(LANES)) u_eval (
    .cur_mask   (mask_q),
    .cond       (cmd_cond),
    .taken      (taken),
    .not_taken  (not_taken),
    .none_taken (none_taken),
    .all_taken  (all_taken)
  );

  simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (st_push),
    .push_rpc   (cmd_rpc),
    .push_else  (st_push_else),
    .push_outer (mask_q),
    .push_loop  (st_loop),
    .pop        (st_pop),
    .clr_en     (st_clr),
    .clr_lanes  (cmd_cond),
    .top_rpc    (top_rpc),
    .top_else   (st_top_else),
    .top_outer  (st_top_outer),
    .sp         (depth),
    .full       (st_full),
    .empty      (st_empty)
  );

  always_comb begin
    mask_d       = mask_q;
    skip_d       = 1'b0;
    div_d        = 1'b0;
    ovf_d        = ovf_q;
    unf_d        = unf_q;
    st_push      = 1'b0;
    st_pop       = 1'b0;
    st_clr       = 1'b0;
    st_loop      = 1'b0;
    st_push_else = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_BRANCH: begin
          if (none_taken) skip_d = 1'b1;
          else if (!all_taken) begin
            if (st_full) ovf_d = 1'b1;
            else begin
              st_push      = 1'b1;
              st_push_else = not_taken;
              mask_d       = taken;
              div_d        = 1'b1;
            end
          end
        end
        OP_ELSE: begin
          if (st_empty) unf_d = 1'b1;
          else begin
            mask_d = st_top_else;
            skip_d = (st_top_else == '0);
          end
        end
        OP_JOIN: begin
          if (st_empty) unf_d = 1'b1;
          else begin
            st_pop = 1'b1;
            mask_d = st_top_outer;
          end
        end
        OP_LOOP: begin
          if (st_full) ovf_d = 1'b1;
          else begin
            st_push = 1'b1;
            st_loop = 1'b1;
          end
        end
        OP_EXIT: begin
          st_clr = 1'b1;
          mask_d = exit_mask;
          skip_d = (exit_mask == '0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      skip_q <= 1'b0;
      div_q  <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      skip_q <= skip_d;
      div_q  <= div_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign lane_we   = mask_q;
  assign path_skip = skip_q;
  assign diverged  = div_q;
  assign ovf_err   = ovf_q;
  assign unf_err   = unf_q;

  // R2: a branch never turns on a lane
  a_r2_branch_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_BRANCH) |=> (lane_we & ~$past(lane_we)) == '0);
  // R2: a divergence pulse accompanies exactly one push
  a_r2_div_push: assert property (@(posedge clk) disable iff (!rst_n)
    diverged |-> depth == $past(depth) + SPW'(1));
  // R7: exited lanes are off afterwards
  a_r7_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_EXIT) |=> (lane_we & $past(cmd_cond)) == '0);
  // R8: overflow is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  // R9: underflow is sticky and the stack stays empty
  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);
  a_r9_unf_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_ELSE || cmd_op == OP_JOIN) && depth == '0)
      |=> unf_err && depth == '0 && $stable(lane_we));
  // R10: an idle cycle holds the mask and depth
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(lane_we) && $stable(depth));
endmodule

// File: tb/simd_pred_ctrl_bench.sv
module simd_pred_ctrl_bench;
  localparam int L  = 4;
  localparam int D  = 2;
  localparam int PW = 16;
  localparam int SW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [L-1:0]  cmd_cond = '0;
  logic [PW-1:0] cmd_rpc = '0;
  logic [L-1:0]  lane_we;
  logic          path_skip, diverged, ovf_err, unf_err;
  logic [PW-1:0] top_rpc;
  logic [SW-1:0] depth;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  simd_pred_ctrl #(.LANES(L), .DEPTH(D), .PCW(PW)) u_simd_pred_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cond(cmd_cond), .cmd_rpc(cmd_rpc),
    .lane_we(lane_we), .path_skip(path_skip), .diverged(diverged),
    .top_rpc(top_rpc), .depth(depth), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [2:0] op, input logic [L-1:0] c, input logic [PW-1:0] r);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_cond = c;
    cmd_rpc = r;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic state(input string tag, input int m, input int d, input int sk, input int dv);
    chk({tag, " mask"}, lane_we, m);
    chk({tag, " depth"}, depth, d);
    chk({tag, " skip"}, path_skip, sk);
    chk({tag, " diverged"}, diverged, dv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int full;
    full = (1 << L) - 1;
    do_reset();
    // R1 reset state
    state("R1", full, 0, 0, 0);
    chk("R1 ovf", ovf_err, 0);
    chk("R1 unf", unf_err, 0);
    chk("R10 ready", cmd_ready, 1);

    // R2 R3 R4 R5: two-level sweep of branch conditions
    for (int a = 0; a < (1 << L); a++) begin
      for (int b = 0; b < (1 << L); b++) begin
        do_reset();
        send(3'd0, L'(a), PW'(16'h1000 + a));
        if (a == 0) begin
          state("R3 skip1", full, 0, 1, 0);
          continue;
        end
        if (a == full) begin
          state("R3 uni1", full, 0, 0, 0);
          continue;
        end
        state("R2 div1", a, 1, 0, 1);
        chk("R2 rpc1", top_rpc, 16'h1000 + a);
        send(3'd0, L'(b), PW'(16'h2000 + b));
        if ((a & b) == 0) state("R3 skip2", a, 1, 1, 0);
        else if ((a & b) == a) state("R3 uni2", a, 1, 0, 0);
        else begin
          state("R2 div2", a & b, 2, 0, 1);
          chk("R2 rpc2", top_rpc, 16'h2000 + b);
          send(3'd1, '0, '0);
          state("R4 else2", a & ~b & full, 2, 0, 0);
          send(3'd2, '0, '0);
          state("R5 join2", a, 1, 0, 0);
          chk("R5 rpc", top_rpc, 16'h1000 + a);
        end
        send(3'd1, '0, '0);
        state("R4 else1", full & ~a, 1, 0, 0);
        send(3'd2, '0, '0);
        state("R5 join1", full, 0, 0, 0);
        chk("R5 rpc empty", top_rpc, 0);
      end
    end

    // R4: empty else path pulses skip (branch inside an exited region)
    do_reset();
    send(3'd0, 4'b0011, 16'h0040);
    send(3'd4, 4'b1100, '0);
    chk("R7 exit no loop mask", lane_we, 4'b0011);
    send(3'd1, '0, '0);
    state("R4 empty else", 0, 1, 1, 0);
    send(3'd2, '0, '0);
    state("R7 join keeps exited", 4'b0011, 0, 0, 0);

    // R6 R7: loop with nested branch and exits
    do_reset();
    send(3'd3, '0, 16'h0100);
    state("R6 loop open", full, 1, 0, 0);
    chk("R6 rpc", top_rpc, 16'h0100);
    send(3'd4, 4'b0001, '0);
    state("R7 exit1", 4'b1110, 1, 0, 0);
    send(3'd0, 4'b0110, 16'h0200);
    state("R7 branch in loop", 4'b0110, 2, 0, 1);
    send(3'd4, 4'b0010, '0);
    state("R7 exit2", 4'b0100, 2, 0, 0);
    send(3'd1, '0, '0);
    state("R7 else after exit", 4'b1000, 2, 0, 0);
    send(3'd2, '0, '0);
    state("R7 inner join", 4'b1100, 1, 0, 0);
    send(3'd4, 4'b1100, '0);
    state("R7 all exit", 0, 1, 1, 0);
    send(3'd2, '0, '0);
    state("R7 loop join", full, 0, 0, 0);

    // R8 overflow
    do_reset();
    send(3'd3, '0, 16'h0001);
    send(3'd3, '0, 16'h0002);
    send(3'd3, '0, 16'h0003);
    state("R8 ovf loop", full, 2, 0, 0);
    chk("R8 ovf flag", ovf_err, 1);
    chk("R8 rpc kept", top_rpc, 16'h0002);
    send(3'd2, '0, '0);
    chk("R8 sticky", ovf_err, 1);
    do_reset();
    send(3'd0, 4'b0111, 16'h0011);
    send(3'd0, 4'b0011, 16'h0012);
    send(3'd0, 4'b0001, 16'h0013);
    state("R8 ovf branch", 4'b0011, 2, 0, 0);
    chk("R8 ovf flag2", ovf_err, 1);

    // R9 underflow
    do_reset();
    send(3'd2, '0, '0);
    state("R9 join empty", full, 0, 0, 0);
    chk("R9 unf", unf_err, 1);
    send(3'd3, '0, 16'h0005);
    chk("R9 sticky", unf_err, 1);
    do_reset();
    send(3'd1, '0, '0);
    state("R9 else empty", full, 0, 0, 0);
    chk("R9 unf2", unf_err, 1);

    // R10 idle, R11 unused opcodes
    do_reset();
    send(3'd0, 4'b0101, 16'h0033);
    cmd_op = 3'd4;
    cmd_cond = '1;
    repeat (3) @(negedge clk);
    state("R10 idle", 4'b0101, 1, 0, 0);
    for (int op = 5; op < 8; op++) begin
      send(3'(op), 4'b0001, 16'h0077);
      state("R11 unused op", 4'b0101, 1, 0, 0);
      chk("R11 rpc", top_rpc, 16'h0033);
      chk("R11 errs", {ovf_err, unf_err}, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule